// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Sticky Flag

This block watches the running calendar time of a real-time clock and raises an alarm flag when the time agrees with a programmed alarm setting. The running time has five fields: seconds, minutes, hours, day of month and month. Each field has its own alarm register. An alarm register holds a 7-bit compare value and a skip bit. When the skip bit is set, that field always counts as agreeing. Because each field can be skipped on its own, one comparator can produce an alarm every second, every minute, every hour, once per day of month or once per month.

The comparison is taken only on the clock cycle that carries the 1 Hz update tick. The flag can be set only while the alarm enable is high. Once set, the flag stays set until software writes a 0 into the flag bit position of the control register write path. Dropping the enable does not clear the flag. An active-low alarm request output follows the flag, so a host can use it as an interrupt line.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous reset, `alarm_flag` is 0 and `alarm_req_n` is 1.
- R2: On a clock edge where `tick_1hz` and `alarm_en` are both 1 and every field agrees with its alarm register, `alarm_flag` reads 1 after that edge.
- R3: While `alarm_en` is 0, an agreeing tick does not set the flag.
- R4: A set flag stays set when `alarm_en` falls, and it stays set across any later ticks.
- R5: A cycle with `ctl_wr` high and bit 6 of `ctl_wdata` equal to 0 clears the flag at that edge. A write with bit 6 equal to 1 leaves the flag as it was. Data presented with `ctl_wr` low has no effect.
- R6: Field i of `alarm_cfg` occupies bits [8i+7:8i] and field i of `time_now` occupies bits [7i+6:7i]. The field order is seconds=0, minutes=1, hours=2, date=3, month=4. Bit 7 of an alarm field is the skip bit. When the skip bit is 1, the field agrees regardless of its value. When the skip bit is 0, the field agrees only if bits 6:0 equal the time field.
- R7: With all skip bits at 1, every enabled tick sets the flag. With only seconds compared, or with seconds through date compared, a difference in any compared field blocks the flag. A difference in a skipped field does not block it.
- R8: Agreement in a cycle without `tick_1hz` never sets the flag. After a clear, a match that persists between ticks does not set the flag again until the next tick.
- R9: If a setting event and a clearing write occur in the same cycle, the flag is 1 afterwards.
- R10: `alarm_req_n` is low exactly when `alarm_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse on each timekeeping update |
| time_now | input | 35 | Five 7-bit current time fields, seconds in the low bits |
| alarm_cfg | input | 40 | Five 8-bit alarm fields: skip bit 7, compare value 6:0 |
| alarm_en | input | 1 | Allows matches to set the flag |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data; bit 6 is the flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_req_n | output | 1 | Active-low alarm request |

## Verification
The hardest state to reach is a clear that lands while a match still holds, either between two ticks or in the same cycle as a setting tick. Random stimulus alone seldom produces it, because the time and alarm values must agree. The stimulus therefore draws time and compare values from a very small range so that matches are common. It then adds directed sequences: a clear write between ticks while the time is held constant, and a clear write in the same cycle as a setting tick. The remaining directed sequences change one compared field at a time, and then one skipped field at a time, to exercise each alarm rate.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int NUM_FIELDS = 5;
    localparam int TIME_W     = 7;
    localparam int ALARM_W    = TIME_W + 1;
    localparam int SKIP_BIT   = ALARM_W - 1;
    localparam int CTL_W      = 8;
    localparam int FLAG_POS   = 6;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4
    } field_e;

    typedef struct packed {
        logic              skip;
        logic [TIME_W-1:0] value;
    } alarm_fld_t;

    typedef struct packed {
        logic set_ev;
        logic clr_ev;
    } flag_evt_t;

    function automatic logic field_agrees(alarm_fld_t cfg, logic [TIME_W-1:0] now);
        return cfg.skip || (cfg.value == now);
    endfunction
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input  logic [TW:0]   cfg,
    input  logic [TW-1:0] now,
    output logic          hit
);
    alarm_fld_t fld;

    always_comb begin
        fld = alarm_fld_t'(cfg);
        hit = field_agrees(fld, now);
    end
endmodule

// File: rtl/alm_match_tree.sv
module alm_match_tree
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int TW = TIME_W,
    localparam int AW = TW + 1
) (
    input  logic [NF*TW-1:0] time_now,
    input  logic [NF*AW-1:0] alarm_cfg,
    output logic             all_hit
);
    logic [NF-1:0] hits;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        alm_field_cmp #(.TW(TW)) u_cmp (
            .cfg (alarm_cfg[i*AW +: AW]),
            .now (time_now[i*TW +: TW]),
            .hit (hits[i])
        );
    end

    assign all_hit = &hits;
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl
    import rtc_alarm_pkg::*;
#(
    parameter int DW   = CTL_W,
    parameter int FPOS = FLAG_POS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          enable,
    input  logic          match,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          flag
);
    flag_evt_t ev;

    always_comb begin
        ev.set_ev = tick && enable && match;
        ev.clr_ev = wr && !wdata[FPOS];
    end

    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (ev.set_ev) flag <= 1'b1;
        else if (ev.clr_ev) flag <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag && !(wr && !wdata[FPOS]) |=> flag); // R4

    AST_SET_NEEDS_TICK_EN: assert property (@(posedge clk) disable iff (rst)
        !flag ##1 flag |-> $past(tick && enable)); // R3

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[FPOS] && !(tick && enable && match)) |=> !flag); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (tick && enable && match) |=> flag); // R9
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int TW = TIME_W,
    parameter int DW = CTL_W,
    parameter int FPOS = FLAG_POS,
    localparam int AW = TW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1hz,
    input  logic [NF*TW-1:0] time_now,
    input  logic [NF*AW-1:0] alarm_cfg,
    input  logic             alarm_en,
    input  logic             ctl_wr,
    input  logic [DW-1:0]    ctl_wdata,
    output logic             alarm_flag,
    output logic             alarm_req_n
);
    logic all_hit;

    alm_match_tree #(.NF(NF), .TW(TW)) u_tree (
        .time_now  (time_now),
        .alarm_cfg (alarm_cfg),
        .all_hit   (all_hit)
    );

    alm_flag_ctl #(.DW(DW), .FPOS(FPOS)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .enable (alarm_en),
        .match  (all_hit),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .flag   (alarm_flag)
    );

    assign alarm_req_n = !alarm_flag;

    AST_NO_SET_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        !alarm_flag && !tick_1hz |=> !alarm_flag); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !alarm_flag && alarm_req_n); // R1
endmodule

// File: tb/tb_rtc_alarm_unit.sv
module tb_rtc_alarm_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 5;
    localparam int TW = 7;
    localparam int AW = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             tick_1hz;
    logic [NF*TW-1:0] time_now;
    logic [NF*AW-1:0] alarm_cfg;
    logic             alarm_en;
    logic             ctl_wr;
    logic [7:0]       ctl_wdata;
    logic             alarm_flag;
    logic             alarm_req_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_unit dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .time_now(time_now),
        .alarm_cfg(alarm_cfg), .alarm_en(alarm_en), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .alarm_flag(alarm_flag), .alarm_req_n(alarm_req_n)
    );

    function automatic logic model_hit(logic [NF*TW-1:0] t, logic [NF*AW-1:0] a);
        logic ok = 1'b1;
        for (int i = 0; i < NF; i++) begin
            if (!a[i*AW+7] && (a[i*AW +: 7] != t[i*TW +: TW])) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic model_next(logic cur, logic tk, logic en, logic hit,
                                        logic wr, logic [7:0] wd);
        if (tk && en && hit) return 1'b1;
        if (wr && !wd[6])    return 1'b0;
        return cur;
    endfunction

    task automatic check(string tag);
        n_checks++;
        if (alarm_flag !== exp_flag) begin
            n_fail++;
            $display("FAIL %s alarm_flag actual=%b expected=%b", tag, alarm_flag, exp_flag);
        end
        n_checks++;
        if (alarm_req_n !== !exp_flag) begin
            n_fail++;
            $display("FAIL R10 (%s) alarm_req_n actual=%b expected=%b", tag, alarm_req_n, !exp_flag);
        end
    endtask

    // apply inputs at the falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(logic tk, logic en, logic wr, logic [7:0] wd, string tag);
        tick_1hz = tk; alarm_en = en; ctl_wr = wr; ctl_wdata = wd;
        @(posedge clk);
        exp_flag = model_next(exp_flag, tk, en, model_hit(time_now, alarm_cfg), wr, wd);
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [NF*AW-1:0] all_skip();
        logic [NF*AW-1:0] v = '0;
        for (int i = 0; i < NF; i++) v[i*AW+7] = 1'b1;
        return v;
    endfunction

    task automatic set_field(int i, logic skip, logic [6:0] val, logic [6:0] now);
        alarm_cfg[i*AW +: AW] = {skip, val};
        time_now[i*TW +: TW]  = now;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; tick_1hz = 0; alarm_en = 0; ctl_wr = 0; ctl_wdata = 0;
        time_now = '0; alarm_cfg = all_skip();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_flag = 1'b0;
        check("R1 reset");

        // R8: matching seconds, enabled, but no tick
        alarm_cfg = all_skip();
        set_field(0, 1'b0, 7'd5, 7'd5);
        step(0, 1, 0, 8'h00, "R8 no tick");
        step(1, 1, 0, 8'h00, "R2 set on tick");
        // R5: writing 1 to flag bit, or data without strobe
        step(0, 1, 1, 8'hFF, "R5 write one keeps");
        step(0, 1, 0, 8'h00, "R5 no strobe keeps");
        // R4: drop enable, flag stays
        step(0, 0, 0, 8'h00, "R4 enable low keeps");
        step(1, 0, 0, 8'h00, "R4 tick keeps");
        step(0, 0, 1, 8'hBF, "R5 clear");
        // R3: disabled match ignored
        step(1, 0, 0, 8'h00, "R3 disabled no set");
        // R9: set and clear together
        step(1, 1, 1, 8'h00, "R9 set wins");
        // R8: clear while match persists between ticks
        step(0, 1, 1, 8'h00, "R8 clear mid second");
        step(0, 1, 0, 8'h00, "R8 no reset without tick");
        step(1, 1, 0, 8'h00, "R8 next tick sets");
        step(0, 1, 1, 8'h00, "R5 clear");

        // R7: rate patterns
        alarm_cfg = all_skip();
        time_now = 35'h1234567;
        step(1, 1, 0, 8'h00, "R7 every second");
        step(0, 1, 1, 8'h00, "R5 clear");
        for (int k = 1; k <= 4; k++) begin
            alarm_cfg = all_skip();
            for (int i = 0; i < NF; i++) set_field(i, 1'b1, 7'd9, 7'd3);
            for (int i = 0; i < k; i++) set_field(i, 1'b0, 7'(i + 10), 7'(i + 10));
            set_field(k, 1'b1, 7'd1, 7'd2);      // skipped field differs
            step(1, 1, 0, 8'h00, "R7 compared fields agree");
            step(0, 1, 1, 8'h00, "R5 clear");
            set_field(k - 1, 1'b0, 7'd0, 7'd1);  // compared field differs
            step(1, 1, 0, 8'h00, "R7 compared field differs");
        end
        // month compared
        for (int i = 0; i < NF; i++) set_field(i, 1'b0, 7'd2, 7'd2);
        step(1, 1, 0, 8'h00, "R6 all fields agree");
        step(0, 1, 1, 8'h00, "R5 clear");
        set_field(4, 1'b0, 7'd7, 7'd2);
        step(1, 1, 0, 8'h00, "R6 month differs");

        // random mix with small value range to make matches common
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NF; i++)
                set_field(i, ($urandom % 3) == 0, 7'($urandom % 2), 7'($urandom % 2));
            step(($urandom % 2) == 1, ($urandom % 4) != 0, ($urandom % 5) == 0,
                 8'($urandom), "R6 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule